// File: doc/BRIEF.md
# Half-Duplex Serial ADC Conversion Controller

This block runs single conversions on a small 12-bit serial analog-to-digital converter. The converter has an active-low select, a serial clock, and one data line that is used in both directions. A one-cycle start request carries a channel choice. The block then builds a 4-bit setup word, selects the converter and clocks the word out on the data line. Next it lets go of the line and clocks in a 12-bit sample. At the end it deselects the converter and hands the sample over with a one-cycle done pulse.

The serial clock comes from the system clock. Each half of the serial clock lasts `DIV` system clocks. Every conversion starts with a guard interval of one full serial-clock period with select still high, so two back-to-back conversions are always separated by that much deselect time. The shared line appears at the block's edge as a separate output value, output enable and input value, so a pad-level tristate can be wired outside it.

Top module: `serial_adc_reader`

## Requirements
- R1: While reset is held, `cs_n` is 1, `sclk` is 0, `sdio_oe` is 0, `busy` is 0, `done` is 0 and `result` is 0.
- R2: A `start` sampled high while the block is idle is accepted. `busy` is 1 from the next cycle until the cycle in which `done` pulses, and `done` lasts exactly one cycle.
- R3: The setup word has bit 3 = 1, bit 2 = `chan_sel`, bit 1 = 1 and bit 0 = 1. It is sent bit 0 first, one bit per serial clock, on `sdio_o`. Each bit is stable from before its rising edge until its falling edge.
- R4: `cs_n` falls 2·DIV cycles after the accepting edge, which is before the first rising edge of `sclk`. It rises in the cycle `done` pulses.
- R5: `sclk` is low whenever `cs_n` is high. Each phase lasts DIV system clocks. There are exactly 16 rising edges per conversion.
- R6: `sdio_oe` is 1 from the fall of `cs_n` through the fourth setup bit. It drops on the falling `sclk` edge after that bit, before the converter drives the line.
- R7: Twelve result bits are taken from `sdio_i` most significant bit first, on rising edges 5 to 16. Each bit is captured at the falling edge that ends its clock pulse.
- R8: `result` changes only in the cycle `done` is high, and it holds its value until the next done.
- R9: A `start` while `busy` is high has no effect on the running conversion or on its outputs.
- R10: Between two conversions `cs_n` stays high for at least 2·DIV system clocks, even when `start` is held high.
- R11: `done` pulses 34·DIV cycles after the edge that accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled while idle |
| chan_sel | input | 1 | Channel choice placed in setup bit 2 |
| sclk | output | 1 | Serial clock to the converter |
| cs_n | output | 1 | Active-low converter select |
| sdio_o | output | 1 | Value driven on the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdio_i | input | 1 | Value read from the shared data line |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | RES_W | Last converted sample |

## Verification
The embedded properties assume that the converter never drives the line while `sdio_oe` is high. They also assume that `start` is synchronous to `clk`, and that `sdio_i` is stable around each falling `sclk` edge. The bench models the converter so that it meets these assumptions. It counts rising `sclk` edges while selected, begins driving only after the fourth one, and changes `sdio_i` one time unit after each falling edge. It drives `start` and `chan_sel` a short delay after the falling system-clock edge, so every input is stable at the sampling edge.

// File: rtl/serial_adc_reader.sv
module serial_adc_reader #(
  parameter int DIV   = 4,
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             chan_sel,
  output logic             sclk,
  output logic             cs_n,
  output logic             sdio_o,
  output logic             sdio_oe,
  input  logic             sdio_i,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result
);

  localparam int CFG_W   = 4;
  localparam int GUARD   = 2;
  localparam int CFG_END = GUARD + 2*CFG_W - 1;
  localparam int RD_LO   = CFG_END + 2;
  localparam int LAST_K  = GUARD + 2*(CFG_W + RES_W) - 1;
  localparam int KW      = $clog2(LAST_K + 1);
  localparam int DW      = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CFG_W-1:0] FORCE_ONES = 4'b1011;

  logic             run;
  logic [KW-1:0]    k;
  logic [DW-1:0]    div_cnt;
  logic [CFG_W-1:0] cfg_sh;
  logic [RES_W-1:0] sh;

  wire tick      = (div_cnt == DW'(DIV - 1));
  wire in_frame  = run && (k >= KW'(GUARD));
  wire cfg_phase = in_frame && (k <= KW'(CFG_END));
  wire rd_edge   = tick && k[0] && (k >= KW'(RD_LO));
  wire cfg_shift = tick && k[0] && cfg_phase;

  assign busy    = run;
  assign cs_n    = !in_frame;
  assign sclk    = in_frame && k[0];
  assign sdio_oe = cfg_phase;
  assign sdio_o  = cfg_phase && cfg_sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      k       <= '0;
      div_cnt <= '0;
      cfg_sh  <= '0;
      sh      <= '0;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        div_cnt <= '0;
        if (start) begin
          run    <= 1'b1;
          k      <= '0;
          cfg_sh <= FORCE_ONES | (CFG_W'(chan_sel) << 2);
        end
      end else begin
        div_cnt <= tick ? '0 : div_cnt + 1'b1;
        if (rd_edge)   sh     <= {sh[RES_W-2:0], sdio_i};
        if (cfg_shift) cfg_sh <= cfg_sh >> 1;
        if (tick) begin
          if (k == KW'(LAST_K)) begin
            run    <= 1'b0;
            done   <= 1'b1;
            result <= {sh[RES_W-2:0], sdio_i};
          end else begin
            k <= k + 1'b1;
          end
        end
      end
    end
  end

  AST_RESET_IDLE:    assert property (@(posedge clk) !rst_n |-> cs_n && !sclk && !busy); // R1
  AST_DONE_ONE:      assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
  AST_DONE_ENDS:     assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy && cs_n); // R4
  AST_SDO_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) sclk |-> $stable(sdio_o)); // R3
  AST_SEL_BUSY:      assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> busy); // R4
  AST_SCLK_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R5
  AST_OE_SELECTED:   assert property (@(posedge clk) disable iff (!rst_n) sdio_oe |-> !cs_n); // R6
  AST_RESULT_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) !$stable(result) |-> done); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) run && start && !tick |=> $stable(k)); // R9
  AST_GAP_AFTER:     assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |=> cs_n); // R10

endmodule

// File: tb/serial_adc_reader_tb.sv
module serial_adc_reader_tb_top;
  localparam int DIV   = 4;
  localparam int RES_W = 12;
  localparam int CONV  = 34*DIV;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, chan_sel = 1'b0, sdio_i = 1'b0;
  logic sclk, cs_n, sdio_o, sdio_oe, busy, done;
  logic [RES_W-1:0] result;

  serial_adc_reader #(.DIV(DIV), .RES_W(RES_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
    .sclk(sclk), .cs_n(cs_n), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdio_i(sdio_i),
    .busy(busy), .done(done), .result(result));

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: conversion age in cycles, decoded to expected pins
  bit m_run = 0, m_chan = 0, e_done = 0;
  int m_t = 0;
  logic [RES_W-1:0] e_res = '0;
  logic [RES_W-1:0] conv_val = '0;
  logic [RES_W-1:0] vals[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; e_done = 0; e_res = '0;
    end else if (m_run) begin
      m_t++;
      e_done = (m_t == CONV);
      if (e_done) begin m_run = 0; e_res = conv_val; end
    end else begin
      e_done = 0;
      if (start) begin m_run = 1; m_t = 0; m_chan = chan_sel; end
    end
  end

  // Converter model on the shared line
  logic [3:0] cap = '0;
  int rcnt = 0;
  bit drv = 0, seen = 0;

  always @(negedge cs_n or posedge sclk) begin
    if (!sclk) begin
      rcnt = 0; seen = 1;
      conv_val = (vals.size() > 0) ? vals.pop_front() : '0;
    end else if (!cs_n) begin
      if (rcnt < 4) cap[rcnt] = sdio_o;
      rcnt++;
      if (rcnt == 4) chk(cap == {1'b1, m_chan, 2'b11}, "R3", "setup word", cap, {1'b1, m_chan, 2'b11});
    end
  end

  always @(negedge sclk) begin
    if (!cs_n && rcnt >= 4 && rcnt < 16) begin
      #1;
      drv = 1;
      sdio_i = conv_val[15-rcnt];
    end
  end

  always @(posedge cs_n) begin
    if (rst_n && seen) begin
      chk(rcnt == 16, "R5", "rising sclk edges", rcnt, 16);
      drv = 0;
    end
  end

  // Per-cycle comparison away from the active edge
  int cs_hi = 0;
  bit had_frame = 0, prev_cs = 1;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int k;
      bit e_sclk, e_cs, e_oe, e_sdo;
      logic [3:0] cfg;
      k = m_t / DIV;
      cfg = {1'b1, m_chan, 2'b11};
      e_sclk = m_run && k >= 3 && (k % 2 == 1);
      e_cs   = !(m_run && k >= 2);
      e_oe   = m_run && k >= 2 && k <= 9;
      e_sdo  = e_oe ? cfg[(k-2)/2] : 1'b0;
      chk(sclk === e_sclk, "R5", "sclk", sclk, e_sclk);
      chk(cs_n === e_cs, "R4", "cs_n", cs_n, e_cs);
      chk(sdio_oe === e_oe, "R6", "sdio_oe", sdio_oe, e_oe);
      chk(sdio_o === e_sdo, "R3", "sdio_o", sdio_o, e_sdo);
      chk(busy === m_run, "R2 R9", "busy", busy, m_run);
      chk(done === e_done, "R11", "done", done, e_done);
      chk(result === e_res, "R8", "result", result, e_res);
      if (done) chk(result === conv_val, "R7", "sample value", result, conv_val);
      chk(!(sdio_oe && drv), "R6", "line contention", sdio_oe, 0);
      if (cs_n) cs_hi++;
      else if (prev_cs) begin
        if (had_frame) chk(cs_hi >= 2*DIV, "R10", "deselect gap", cs_hi, 2*DIV);
        had_frame = 1; cs_hi = 0;
      end
      prev_cs = cs_n;
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic run_conv(bit ch, logic [RES_W-1:0] v);
    vals.push_back(v);
    @(negedge clk); #2 chan_sel = ch; start = 1'b1;
    @(negedge clk); #2 start = 1'b0;
    do @(negedge clk); while (!done);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1, "R1", "cs_n in reset", cs_n, 1);
    chk(sclk === 1'b0, "R1", "sclk in reset", sclk, 0);
    chk(sdio_oe === 1'b0, "R1", "oe in reset", sdio_oe, 0);
    chk(busy === 1'b0, "R1", "busy in reset", busy, 0);
    chk(done === 1'b0, "R1", "done in reset", done, 0);
    chk(result === '0, "R1", "result in reset", result, 0);
    #2 rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_conv(1'b0, 12'hA5C);
    run_conv(1'b1, 12'h3F1);
    run_conv(1'b0, 12'h801);

    // R9: extra requests mid-conversion with the other channel
    vals.push_back(12'h6B4);
    @(negedge clk); #2 chan_sel = 1'b1; start = 1'b1;
    @(negedge clk); #2 start = 1'b0;
    repeat (40) @(negedge clk);
    #2 chan_sel = 1'b0; start = 1'b1;
    @(negedge clk); #2 start = 1'b0;
    repeat (30) @(negedge clk);
    #2 start = 1'b1;
    @(negedge clk); #2 start = 1'b0;
    do @(negedge clk); while (!done);
    repeat (3) @(negedge clk);

    // R10: start held high across back-to-back conversions
    vals.push_back(12'hFFF);
    vals.push_back(12'h000);
    @(negedge clk); #2 chan_sel = 1'b1; start = 1'b1;
    do @(negedge clk); while (!done);
    do @(negedge clk); while (!done);
    #2 start = 1'b0;
    repeat (5) @(negedge clk);
    chk(cs_n === 1'b1 && busy === 1'b0, "R2", "idle after done", busy, 0);
    finish_run();
  end

  initial begin
    #(200000*8);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end
endmodule